// File: doc/BRIEF.md
# Presence-Detect Serial Memory Slave

This block is a two-wire serial bus slave that behaves like a small 256-byte identification memory on a memory module. A free-running system clock oversamples the bus clock and data lines. Each line is synchronised and then passed through a short glitch filter. The block detects start and stop conditions, matches its slave address, and pulls the data line low through an open-drain style output whenever it acknowledges or sends a zero bit.

A bus master uses it in three ways:
- A write sets the word pointer from the first byte after the address, then stores any further bytes at that pointer.
- A random read sets the pointer with a write, issues a repeated start and then reads.
- A sequential read continues from byte to byte for as long as the master acknowledges.

After a stop that ends a write carrying data, the block models a programming interval. During that interval it does not answer its own address.

The storage is a register array. At reset each byte is filled from a seeded formula, and byte 63 is loaded with the 8-bit sum of bytes 0 to 62.

Top module: `pdee_slave`

## Requirements
- R1: The data-line output only changes while the filtered bus clock is low; it is held steady through every clock-high phase.
- R2: Bus activity that is not preceded by a start condition (data falling while clock is high) is ignored: no acknowledge is given.
- R3: The slave acknowledges (pulls data low in the ninth clock) only an address byte whose upper seven bits equal the 4-bit device code (default 1010b) followed by the 3-bit strap input; bit 0 is the read (1) / write (0) flag. Any other address is not acknowledged.
- R4: In a write, the first byte after the address loads the word pointer, each following byte is stored at the pointer and the pointer advances; every byte is acknowledged.
- R5: A write of the pointer followed by a repeated start and a read address returns the byte stored at that pointer, most significant bit first.
- R6: While the master acknowledges, reading continues with the next location; the pointer wraps from 255 to 0.
- R7: When the master does not acknowledge a read byte, the slave drives no further bits until the next start or stop.
- R8: A stop condition (data rising while clock is high) returns the slave to standby with the data line released; after reset the data line is released.
- R9: After a stop that ends a write containing at least one data byte, the slave does not acknowledge its address for BUSY_CYCLES system clocks (default 2000), and acknowledges again after that.
- R10: After reset, byte i holds (i*37 + 11) mod 256 for every i except 63, and byte 63 holds the low 8 bits of the sum of bytes 0 to 62.
- R11: A pulse on the bus clock shorter than FILT_LEN system clocks (default 4) is not counted as a clock edge.
- R12: A write that only sets the pointer and carries no data byte does not start the busy interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| strapAddr | input | 3 | Strap bits that select one of eight slave addresses |
| sdaDrvLow | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions rely on the bus master following the line discipline: data changes only while the clock is low, the clock is steady for several filter lengths around every data change, and the master never issues a start or stop while the slave holds data low. The stimulus moves one line at a time, with quarter bit periods of ten system clocks that are well above the filter length. It ends every read with a not-acknowledge before any stop. Glitches are injected only on the clock line and only while data is steady.

// File: rtl/pdee_pkg.sv
package pdee_pkg;
  localparam int PTR_W     = 8;
  localparam int DEPTH     = 1 << PTR_W;
  localparam int CKSUM_IDX = 63;

  typedef enum logic [1:0] {DRV_REL, DRV_ACK, DRV_DATA} pdeeDrive_e;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadRd;
    logic setPtr;
    logic wrMem;
  } pdeeStrobe_t;

  function automatic logic [7:0] seedByte(input int idx, input logic [7:0] mul,
                                          input logic [7:0] add);
    logic [15:0] prod;
    prod = 16'(idx) * 16'(mul) + 16'(add);
    return prod[7:0];
  endfunction

  function automatic logic [7:0] sumBelow(input logic [7:0] mul, input logic [7:0] add);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < CKSUM_IDX; i++) acc = acc + seedByte(i, mul, add);
    return acc;
  endfunction
endpackage

// File: rtl/pdee_filter.sv
module pdee_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0] rawIn;
  logic [1:0] lvl;
  logic [1:0] prevLvl;

  assign rawIn = {sdaRaw, sclRaw};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] cnt;
    logic             lvlQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        cnt   <= '0;
        lvlQ  <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        if (syncQ[1] == lvlQ) begin
          cnt <= '0;
        end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
          cnt  <= '0;
          lvlQ <= syncQ[1];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign lvl[g] = lvlQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 2'b11;
    else       prevLvl <= lvl;
  end

  assign sclLvl   = lvl[0];
  assign sdaLvl   = lvl[1];
  assign sclRise  = lvl[0] & ~prevLvl[0];
  assign sclFall  = ~lvl[0] & prevLvl[0];
  assign startDet = lvl[0] & prevLvl[0] & prevLvl[1] & ~lvl[1];
  assign stopDet  = lvl[0] & prevLvl[0] & ~prevLvl[1] & lvl[1];
endmodule

// File: rtl/pdee_ctrl.sv
module pdee_ctrl
  import pdee_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'hA,
  parameter int         BUSY_CYCLES = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sdaLvl,
  input  logic [7:0]  rxByte,
  input  logic [2:0]  strapAddr,
  output pdeeStrobe_t stb,
  output pdeeDrive_e  drvMode
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK} state_e;

  state_e            state;
  logic [2:0]        bitCnt;
  logic              gotByte, firstByte, rdMode, ackSeen, wrPending;
  logic [BUSY_W-1:0] busyCnt;
  logic              busy, addrHit;

  assign busy    = (busyCnt != '0);
  assign addrHit = (rxByte[7:1] == {DEV_CODE, strapAddr}) && !busy;

  always_comb begin
    stb.shiftIn  = sclRise && (state == S_ADDR || state == S_WR);
    stb.shiftOut = sclFall && (state == S_RD);
    stb.loadRd   = sclFall && ((state == S_ADDR_ACK && rdMode) || (state == S_RD_ACK && ackSeen));
    stb.setPtr   = sclFall && (state == S_WR) && gotByte && firstByte;
    stb.wrMem    = sclFall && (state == S_WR) && gotByte && !firstByte;
    case (state)
      S_ADDR_ACK, S_WR_ACK: drvMode = DRV_ACK;
      S_RD:                 drvMode = DRV_DATA;
      default:              drvMode = DRV_REL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      gotByte   <= 1'b0;
      firstByte <= 1'b0;
      rdMode    <= 1'b0;
      ackSeen   <= 1'b0;
      wrPending <= 1'b0;
      busyCnt   <= '0;
    end else begin
      if (busy) busyCnt <= busyCnt - 1'b1;
      if (stopDet) begin
        state <= S_IDLE;
        if (wrPending) begin
          busyCnt   <= BUSY_W'(BUSY_CYCLES);
          wrPending <= 1'b0;
        end
      end else if (startDet) begin
        state   <= S_ADDR;
        bitCnt  <= '0;
        gotByte <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) gotByte <= 1'b1;
            end
            if (sclFall && gotByte) begin
              gotByte <= 1'b0;
              bitCnt  <= '0;
              if (state == S_ADDR) begin
                if (addrHit) begin
                  rdMode <= rxByte[0];
                  state  <= S_ADDR_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                if (!firstByte) wrPending <= 1'b1;
                firstByte <= 1'b0;
                state     <= S_WR_ACK;
              end
            end
          end
          S_ADDR_ACK: if (sclFall) begin
            state     <= rdMode ? S_RD : S_WR;
            firstByte <= 1'b1;
            bitCnt    <= '0;
          end
          S_WR_ACK: if (sclFall) state <= S_WR;
          S_RD: if (sclFall) begin
            if (bitCnt == 3'd7) begin
              state  <= S_RD_ACK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
          S_RD_ACK: begin
            if (sclRise) ackSeen <= !sdaLvl;
            if (sclFall) state <= ackSeen ? S_RD : S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_TO_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == S_IDLE)); // R8
  AST_START_TO_ADDRESS: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_ADDR)); // R2
  AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (drvMode == DRV_REL)); // R9
endmodule

// File: rtl/pdee_dpath.sv
module pdee_dpath
  import pdee_pkg::*;
#(
  parameter logic [7:0] SEED_MUL = 8'd37,
  parameter logic [7:0] SEED_ADD = 8'd11
) (
  input  logic        clk,
  input  logic        rstN,
  input  pdeeStrobe_t stb,
  input  pdeeDrive_e  drvMode,
  input  logic        sdaLvl,
  input  logic        sclLvl,
  output logic [7:0]  rxByte,
  output logic        sdaDrvLow
);
  localparam logic [7:0] CKSUM = sumBelow(SEED_MUL, SEED_ADD);

  logic [7:0]       memArr [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        memArr[i] <= (i == CKSUM_IDX) ? CKSUM : seedByte(i, SEED_MUL, SEED_ADD);
      ptr    <= '0;
      shiftQ <= '0;
    end else begin
      if (stb.shiftIn) begin
        shiftQ <= {shiftQ[6:0], sdaLvl};
      end else if (stb.shiftOut) begin
        shiftQ <= {shiftQ[6:0], 1'b0};
      end else if (stb.loadRd) begin
        shiftQ <= memArr[ptr];
        ptr    <= ptr + 1'b1;
      end
      if (stb.setPtr) ptr <= shiftQ;
      if (stb.wrMem) begin
        memArr[ptr] <= shiftQ;
        ptr         <= ptr + 1'b1;
      end
    end
  end

  assign rxByte    = shiftQ;
  assign sdaDrvLow = (drvMode == DRV_ACK) || (drvMode == DRV_DATA && !shiftQ[7]);

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl)) |-> $stable(sdaDrvLow)); // R1
endmodule

// File: rtl/pdee_slave.sv
module pdee_slave
  import pdee_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'hA,
  parameter int         FILT_LEN    = 4,
  parameter int         BUSY_CYCLES = 2000,
  parameter logic [7:0] SEED_MUL    = 8'd37,
  parameter logic [7:0] SEED_ADD    = 8'd11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  output logic       sdaDrvLow
);
  logic        sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0]  rxByte;
  pdeeStrobe_t stb;
  pdeeDrive_e  drvMode;

  pdee_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  pdee_ctrl #(.DEV_CODE(DEV_CODE), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl), .rxByte(rxByte),
    .strapAddr(strapAddr), .stb(stb), .drvMode(drvMode)
  );

  pdee_dpath #(.SEED_MUL(SEED_MUL), .SEED_ADD(SEED_ADD)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .drvMode(drvMode), .sdaLvl(sdaLvl),
    .sclLvl(sclLvl), .rxByte(rxByte), .sdaDrvLow(sdaDrvLow)
  );
endmodule

// File: tb/pdee_slave_tb.sv
module pdee_slave_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 10;
  localparam int         BUSY       = 2000;
  localparam logic [2:0] STRAP      = 3'b101;
  localparam logic [15:0] VEC [6] = '{16'h005A, 16'h3FC0, 16'hFFA5,
                                      16'h8001, 16'h07FF, 16'h4100};

  logic clk = 1'b0, rstN = 1'b0, mScl = 1'b1, mSda = 1'b1;
  logic sdaDrvLow;
  wire  sdaBus = mSda & ~sdaDrvLow;
  int   checks = 0, fails = 0, r1Viol = 0;
  logic [7:0] model [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pdee_slave u_dut (.clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
                    .strapAddr(STRAP), .sdaDrvLow(sdaDrvLow));

  always @(sdaDrvLow) if (rstN && mScl) r1Viol++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1'b1; waitClk(Q); mScl = 1'b1; waitClk(Q);
    mSda = 1'b0; waitClk(Q); mScl = 1'b0; waitClk(Q);
  endtask

  task automatic i2cStop();
    mSda = 1'b0; waitClk(Q); mScl = 1'b1; waitClk(Q); mSda = 1'b1; waitClk(Q);
  endtask

  task automatic sendBit(input bit b);
    mSda = b; waitClk(Q); mScl = 1'b1; waitClk(2 * Q); mScl = 1'b0; waitClk(Q);
  endtask

  task automatic readBit(output bit b);
    mSda = 1'b1; waitClk(Q); mScl = 1'b1; waitClk(Q);
    b = sdaBus; waitClk(Q); mScl = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(b);
    acked = !b;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin readBit(b); v[i] = b; end
    sendBit(!ackIt);
  endtask

  task automatic addrPhase(input bit rw, output bit acked);
    i2cStart();
    sendByte({4'hA, STRAP, rw}, acked);
  endtask

  task automatic writeOne(input logic [7:0] p, input logic [7:0] d);
    bit a;
    addrPhase(1'b0, a); chk(a, "R4", "write address ack", a, 1);
    sendByte(p, a);     chk(a, "R4", "pointer byte ack", a, 1);
    sendByte(d, a);     chk(a, "R4", "data byte ack", a, 1);
    i2cStop();
    model[p] = d;
  endtask

  task automatic setPtrRead(input logic [7:0] p);
    bit a;
    addrPhase(1'b0, a);
    sendByte(p, a);
    addrPhase(1'b1, a); chk(a, "R5", "read address ack", a, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a, b;
    logic [7:0] v;
    logic [7:0] sum;
    int lows;
    for (int i = 0; i < 256; i++) model[i] = 8'((i * 37 + 11) % 256);
    sum = '0;
    for (int i = 0; i < 63; i++) sum = sum + model[i];
    model[63] = sum;

    waitClk(5); rstN = 1'b1; waitClk(10);
    chk(sdaDrvLow == 1'b0, "R8", "released after reset", sdaDrvLow, 0);

    // R2: address bits without a start condition
    mScl = 1'b0; waitClk(Q);
    sendByte({4'hA, STRAP, 1'b0}, a);
    chk(!a, "R2", "no ack without start", a, 0);
    mScl = 1'b1; waitClk(Q);

    // R10 / R6 / R5: sequential read of bytes 0..63 after reset
    setPtrRead(8'h00);
    sum = '0;
    for (int i = 0; i < 64; i++) begin
      recvByte(i != 63, v);
      if (i < 63) begin
        sum = sum + v;
        chk(v == 8'((i * 37 + 11) % 256), "R10", "seeded byte", v, (i * 37 + 11) % 256);
      end else begin
        chk(v == sum, "R10", "checksum byte 63", v, sum);
      end
    end
    i2cStop();

    // R12: pointer-only write leaves the slave answering
    addrPhase(1'b0, a);
    chk(a, "R12", "ack right after pointer-only write", a, 1);
    i2cStop();

    // R3: address mismatches
    i2cStart(); sendByte({4'hA, 3'b100, 1'b0}, a);
    chk(!a, "R3", "wrong strap not acked", a, 0);
    i2cStop();
    i2cStart(); sendByte({4'hB, STRAP, 1'b1}, a);
    chk(!a, "R3", "wrong device code not acked", a, 0);
    i2cStop();
    chk(sdaDrvLow == 1'b0, "R8", "released after stop", sdaDrvLow, 0);

    // R11: short clock pulse inside an address byte
    i2cStart();
    begin
      logic [7:0] ad;
      ad = {4'hA, STRAP, 1'b0};
      for (int i = 7; i >= 0; i--) begin
        sendBit(ad[i]);
        if (i == 4) begin mScl = 1'b1; waitClk(2); mScl = 1'b0; waitClk(Q); end
      end
    end
    readBit(b);
    chk(!b, "R11", "glitch ignored, address acked", !b, 1);
    i2cStop();

    // R4 / R5: write-then-read vectors
    for (int k = 0; k < 6; k++) begin
      writeOne(VEC[k][15:8], VEC[k][7:0]);
      waitClk(BUSY + 200);
      setPtrRead(VEC[k][15:8]);
      recvByte(1'b0, v);
      i2cStop();
      chk(v == VEC[k][7:0], "R4", "read back written byte", v, VEC[k][7:0]);
    end

    // R9: busy interval after a data write
    writeOne(8'h10, 8'hC3);
    addrPhase(1'b0, a);
    chk(!a, "R9", "no ack during program time", a, 0);
    i2cStop();
    waitClk(BUSY);
    addrPhase(1'b0, a);
    chk(a, "R9", "ack after program time", a, 1);
    i2cStop();

    // R6: sequential read wraps from 255 to 0
    setPtrRead(8'hFE);
    recvByte(1'b1, v); chk(v == model[254], "R6", "byte 254", v, model[254]);
    recvByte(1'b1, v); chk(v == model[255], "R6", "byte 255", v, model[255]);
    recvByte(1'b0, v); chk(v == model[0], "R6", "wrap to byte 0", v, model[0]);
    i2cStop();

    // R7: after a not-acknowledge the slave sends nothing more
    setPtrRead(8'h05);
    recvByte(1'b0, v);
    chk(v == model[5], "R5", "random read byte 5", v, model[5]);
    lows = 0;
    for (int i = 0; i < 9; i++) begin readBit(b); if (!b) lows++; end
    chk(lows == 0, "R7", "low bits after nack", lows, 0);
    i2cStop();

    // R8: standby after stop, slave usable again
    setPtrRead(8'h10);
    recvByte(1'b0, v);
    i2cStop();
    chk(v == 8'hC3, "R8", "read after stop", v, 8'hC3);

    chk(r1Viol == 0, "R1", "output changes while SCL high", r1Viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule